// File: doc/BRIEF.md
# Master-Trailer Lockstep Recovery Controller

This block keeps two copies of a small accumulator-style register set. The master copy runs the live input stream and is watched by an external on-line checker. The trailer copy applies the same accepted inputs one cycle later, so it always holds the state the master had one cycle earlier. The block keeps a one-entry buffer of the most recent input, and the trailer consumes that buffer.

When the checker raises its error line, the block assumes a transient upset. It rebuilds the master from the trailer, replays the buffered input, and resumes within two clock edges. If another error arrives within a short window after a repair, the block treats the fault as permanent. It then hands the function to the trailer, which from that point runs the live stream directly and feeds the read port. An error reported during the repair cycle itself leaves no trustworthy copy, and the block locks into a failed state until reset.

Inputs are accepted only when `busy_o` is low. Software or a sequencer reads registers through a combinational read port that always shows the copy currently in charge.

Top module: `lsr_lockstep_ctrl`

## Requirements
- R1: After reset, status_o is 2'b00, busy_o is 0 and every register reads 0.
- R2: With status 00 and in_valid_i high, the register chosen by in_sel_i is updated at the clock edge by in_op_i (0 load, 1 add, 2 xor, 3 subtract, arithmetic modulo 2^W) and reads back the new value afterwards; fault_flip_i is XORed into the master write value only.
- R3: An error reported with status 00 and no repair in the last K cycles gives one cycle with status 01 and busy high, after which status returns to 00 and every register reads the fault-free value.
- R4: The input presented in the cycle that raises the error is kept and applied; inputs presented while busy_o is high are dropped.
- R5: An error reported during the K cycles that follow a completed repair gives one cycle with status 10 and busy high, then status 10 with busy low and register values equal to the fault-free result of every accepted input.
- R6: An error arriving once the K cycles after a repair have passed is repaired again as in R3, not taken over.
- R7: After takeover, errors and fault masks have no effect; inputs keep being executed and stay readable.
- R8: An error reported while status is 01 gives status 11 with busy high; reads return 0 and inputs are ignored until reset.
- R9: A cycle with in_valid_i low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input operation present this cycle |
| in_op_i | input | 2 | Operation code (load, add, xor, subtract) |
| in_sel_i | input | SW | Destination register index |
| in_data_i | input | W | Operand |
| fault_flip_i | input | W | Upset mask XORed into the master write value |
| err_i | input | 1 | On-line checker reports a corrupt master |
| rd_sel_i | input | SW | Read port register index |
| rd_data_o | output | W | Register value from the copy in charge |
| status_o | output | 2 | 00 normal, 01 repairing, 10 taken over, 11 failed |
| busy_o | output | 1 | Inputs are dropped this cycle |

## Verification
On every cycle, the assertions check the state sequencing. A first error leads to one repair cycle, and a repair with no new error goes back to normal with the trailer held. A recurring error leads through exactly one switching cycle to takeover. The failed and taken-over states are sticky, and they freeze the master. Idle cycles leave the master alone, and the recurrence counter stays bounded. Only the bench scenarios can show the actual values: that the rebuilt master and the trailer after takeover both hold the fault-free result. They also show that the input in the error cycle survives while busy-cycle inputs vanish, and that the window boundary falls exactly K cycles after a repair.

// File: rtl/lsr_pkg.sv
`timescale 1ns/1ps
package lsr_pkg;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_ADD  = 2'd1,
        OP_XOR  = 2'd2,
        OP_SUB  = 2'd3
    } lsr_op_e;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_REPAIR,
        ST_SWITCH,
        ST_TAKEN,
        ST_FAILED
    } lsr_state_e;

    localparam logic [1:0] STAT_NORMAL = 2'b00;
    localparam logic [1:0] STAT_REPAIR = 2'b01;
    localparam logic [1:0] STAT_TAKEN  = 2'b10;
    localparam logic [1:0] STAT_FAILED = 2'b11;

endpackage

// File: rtl/lsr_exec.sv
`timescale 1ns/1ps
// One execution step of the accumulator register set (pure combinational).
module lsr_exec #(
    parameter int W    = 16,
    parameter int NREG = 4,
    localparam int SW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic [NREG-1:0][W-1:0] regs_i,
    input  logic                   vld_i,
    input  lsr_pkg::lsr_op_e       op_i,
    input  logic [SW-1:0]          sel_i,
    input  logic [W-1:0]           dat_i,
    input  logic [W-1:0]           flip_i,
    output logic [NREG-1:0][W-1:0] regs_o
);
    import lsr_pkg::*;

    logic [W-1:0] result;

    always_comb begin
        unique case (op_i)
            OP_LOAD: result = dat_i;
            OP_ADD:  result = regs_i[sel_i] + dat_i;
            OP_XOR:  result = regs_i[sel_i] ^ dat_i;
            default: result = regs_i[sel_i] - dat_i;
        endcase
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_comb begin
            if (vld_i && sel_i == SW'(i)) regs_o[i] = result ^ flip_i;
            else                          regs_o[i] = regs_i[i];
        end
    end

endmodule

// File: rtl/lsr_recur_win.sv
`timescale 1ns/1ps
// Counts the cycles after a repair during which a new error means a permanent fault.
module lsr_recur_win #(
    parameter int K    = 4,
    localparam int CW  = $clog2(K + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic tick_i,
    output logic open_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (arm_i)                      cnt_d = CW'(K);
        else if (tick_i && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign open_o = (cnt_q != '0);

    p_win_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(K));
    p_win_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (cnt_q == CW'(K)));
    p_win_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_i && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/lsr_lockstep_ctrl.sv
`timescale 1ns/1ps
module lsr_lockstep_ctrl #(
    parameter int W    = 16,
    parameter int NREG = 4,
    parameter int K    = 4,
    localparam int SW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid_i,
    input  logic [1:0]    in_op_i,
    input  logic [SW-1:0] in_sel_i,
    input  logic [W-1:0]  in_data_i,
    input  logic [W-1:0]  fault_flip_i,
    input  logic          err_i,
    input  logic [SW-1:0] rd_sel_i,
    output logic [W-1:0]  rd_data_o,
    output logic [1:0]    status_o,
    output logic          busy_o
);
    import lsr_pkg::*;

    typedef logic [NREG-1:0][W-1:0] bank_t;

    typedef struct packed {
        lsr_state_e    st;
        bank_t         mst;
        bank_t         trl;
        logic          bvld;
        lsr_op_e       bop;
        logic [SW-1:0] bsel;
        logic [W-1:0]  bdat;
    } ctl_t;

    ctl_t    ctl_d, ctl_q;
    bank_t   mst_step, trl_buf, trl_live;
    logic    win_open, win_arm, win_tick;
    lsr_op_e in_op;

    assign in_op = lsr_op_e'(in_op_i);

    // Master executes the live input (with the upset mask).
    lsr_exec #(.W(W), .NREG(NREG)) u_mst_exec (
        .regs_i(ctl_q.mst), .vld_i(in_valid_i), .op_i(in_op), .sel_i(in_sel_i),
        .dat_i(in_data_i), .flip_i(fault_flip_i), .regs_o(mst_step)
    );

    // Trailer executes the buffered input; the same result rebuilds the master.
    lsr_exec #(.W(W), .NREG(NREG)) u_trl_exec (
        .regs_i(ctl_q.trl), .vld_i(ctl_q.bvld), .op_i(ctl_q.bop), .sel_i(ctl_q.bsel),
        .dat_i(ctl_q.bdat), .flip_i('0), .regs_o(trl_buf)
    );

    // Trailer executes the live input once it is in charge.
    lsr_exec #(.W(W), .NREG(NREG)) u_own_exec (
        .regs_i(ctl_q.trl), .vld_i(in_valid_i), .op_i(in_op), .sel_i(in_sel_i),
        .dat_i(in_data_i), .flip_i('0), .regs_o(trl_live)
    );

    lsr_recur_win #(.K(K)) u_win (
        .clk(clk), .rst_n(rst_n), .arm_i(win_arm), .tick_i(win_tick), .open_o(win_open)
    );

    assign win_arm  = (ctl_q.st == ST_REPAIR) && !err_i;
    assign win_tick = (ctl_q.st == ST_RUN);

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_RUN: begin
                ctl_d.trl  = trl_buf;
                ctl_d.bvld = in_valid_i;
                ctl_d.bop  = in_op;
                ctl_d.bsel = in_sel_i;
                ctl_d.bdat = in_data_i;
                if (err_i) ctl_d.st  = win_open ? ST_SWITCH : ST_REPAIR;
                else       ctl_d.mst = mst_step;
            end
            ST_REPAIR: begin
                if (err_i) begin
                    ctl_d.st = ST_FAILED;
                end else begin
                    ctl_d.mst = trl_buf;
                    ctl_d.st  = ST_RUN;
                end
            end
            ST_SWITCH: begin
                ctl_d.trl = trl_buf;
                ctl_d.st  = ST_TAKEN;
            end
            ST_TAKEN: ctl_d.trl = trl_live;
            default:  ctl_d = ctl_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_RUN;
            ctl_q.bop  <= OP_LOAD;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (int'(rd_sel_i) < NREG) begin
            unique case (ctl_q.st)
                ST_SWITCH, ST_TAKEN: rd_data_o = ctl_q.trl[rd_sel_i];
                ST_FAILED:           rd_data_o = '0;
                default:             rd_data_o = ctl_q.mst[rd_sel_i];
            endcase
        end
    end

    always_comb begin
        unique case (ctl_q.st)
            ST_RUN:              status_o = STAT_NORMAL;
            ST_REPAIR:           status_o = STAT_REPAIR;
            ST_SWITCH, ST_TAKEN: status_o = STAT_TAKEN;
            default:             status_o = STAT_FAILED;
        endcase
    end

    assign busy_o = (ctl_q.st == ST_REPAIR) || (ctl_q.st == ST_SWITCH) ||
                    (ctl_q.st == ST_FAILED);

    p_first_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_RUN && err_i && !win_open) |=> (ctl_q.st == ST_REPAIR));
    p_repair_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_REPAIR && !err_i) |=> (ctl_q.st == ST_RUN && $stable(ctl_q.trl)));
    p_recur_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_RUN && err_i && win_open) |=>
            (ctl_q.st == ST_SWITCH) ##1 (ctl_q.st == ST_TAKEN));
    p_taken_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_TAKEN) |=> (ctl_q.st == ST_TAKEN && $stable(ctl_q.mst)));
    p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_FAILED) |=>
            (ctl_q.st == ST_FAILED && $stable(ctl_q.mst) && $stable(ctl_q.trl)));
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_RUN && !err_i && !in_valid_i) |=> $stable(ctl_q.mst));

endmodule

// File: tb/tb_lsr_lockstep_ctrl.sv
`timescale 1ns/1ps
module tb_lsr_lockstep_ctrl;
    localparam int W = 16;
    localparam int NREG = 4;
    localparam int K = 4;
    localparam int SW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid_i = 1'b0;
    logic [1:0] in_op_i = '0;
    logic [SW-1:0] in_sel_i = '0;
    logic [W-1:0] in_data_i = '0;
    logic [W-1:0] fault_flip_i = '0;
    logic err_i = 1'b0;
    logic [SW-1:0] rd_sel_i = '0;
    logic [W-1:0] rd_data_o;
    logic [1:0] status_o;
    logic busy_o;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] ref_q [NREG];

    always #2.5 clk = ~clk;

    lsr_lockstep_ctrl #(.W(W), .NREG(NREG), .K(K)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .in_op_i(in_op_i),
        .in_sel_i(in_sel_i), .in_data_i(in_data_i), .fault_flip_i(fault_flip_i),
        .err_i(err_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
        .status_o(status_o), .busy_o(busy_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_regs(input string tag);
        for (int i = 0; i < NREG; i++) begin
            rd_sel_i = SW'(i);
            #0.1;
            chk(tag, 32'(rd_data_o), 32'(ref_q[i]));
        end
    endtask

    task automatic chk_stat(input string tag, input logic [1:0] st, input logic bz);
        chk(tag, {30'd0, status_o}, {30'd0, st});
        chk(tag, {31'd0, busy_o}, {31'd0, bz});
    endtask

    // One clock cycle of stimulus; acc tells whether the bench expects the input to take effect.
    task automatic step(input logic v, input logic [1:0] op, input int sel,
                        input logic [W-1:0] dat, input logic [W-1:0] flip,
                        input logic err, input logic acc);
        @(negedge clk);
        in_valid_i = v; in_op_i = op; in_sel_i = SW'(sel);
        in_data_i = dat; fault_flip_i = flip; err_i = err;
        @(posedge clk);
        #0.5;
        in_valid_i = 1'b0; fault_flip_i = '0; err_i = 1'b0; in_data_i = 16'hA5A5;
        if (v && acc) begin
            case (op)
                2'd0: ref_q[sel] = dat;
                2'd1: ref_q[sel] = ref_q[sel] + dat;
                2'd2: ref_q[sel] = ref_q[sel] ^ dat;
                default: ref_q[sel] = ref_q[sel] - dat;
            endcase
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NREG; i++) ref_q[i] = '0;
        #0.5;
    endtask

    task automatic t_reset();
        chk_stat("R1 reset status", 2'b00, 1'b0);
        chk_regs("R1 reset regs");
    endtask

    task automatic t_normal();
        step(1, 2'd0, 0, 16'd5, 0, 0, 1);
        step(1, 2'd1, 0, 16'd3, 0, 0, 1);
        step(1, 2'd0, 1, 16'h00F0, 0, 0, 1);
        step(1, 2'd2, 1, 16'h000F, 0, 0, 1);
        step(1, 2'd0, 2, 16'd10, 0, 0, 1);
        step(1, 2'd3, 2, 16'd3, 0, 0, 1);
        step(1, 2'd0, 3, 16'h8000, 0, 0, 1);
        step(1, 2'd1, 3, 16'h8001, 0, 0, 1);
        chk_regs("R2 normal execution");
        chk_stat("R2 status normal", 2'b00, 1'b0);
    endtask

    task automatic t_idle();
        step(0, 2'd0, 0, 16'hFFFF, 0, 0, 1);
        step(0, 2'd1, 2, 16'h1234, 0, 0, 1);
        chk_regs("R9 idle cycles");
    endtask

    task automatic t_repair();
        step(1, 2'd1, 0, 16'd1, 16'h0100, 0, 1);
        rd_sel_i = 0; #0.1;
        chk("R2 flip reaches master", 32'(rd_data_o), 32'h0109);
        step(1, 2'd1, 1, 16'd1, 0, 1, 1);
        chk_stat("R3 repairing", 2'b01, 1'b1);
        step(1, 2'd0, 3, 16'hDEAD, 0, 0, 0);
        chk_stat("R3 repair done", 2'b00, 1'b0);
        chk_regs("R4 restored regs, busy input dropped");
    endtask

    task automatic t_window_expire();
        step(0, 2'd0, 0, 0, 0, 0, 1);
        step(0, 2'd0, 0, 0, 0, 0, 1);
        step(0, 2'd0, 0, 0, 0, 0, 1);
        step(1, 2'd1, 2, 16'd1, 16'h0040, 0, 1);
        step(0, 2'd0, 0, 0, 0, 1, 1);
        chk_stat("R6 late error repaired", 2'b01, 1'b1);
        step(1, 2'd0, 0, 16'h4444, 0, 0, 0);
        chk_stat("R6 back to normal", 2'b00, 1'b0);
        chk_regs("R6 regs after second repair");
    endtask

    task automatic t_recur();
        step(1, 2'd1, 0, 16'd1, 0, 0, 1);
        step(1, 2'd1, 1, 16'd1, 16'h0008, 0, 1);
        step(0, 2'd0, 0, 0, 0, 0, 1);
        step(1, 2'd2, 3, 16'h00FF, 0, 1, 1);
        chk_stat("R5 switching", 2'b10, 1'b1);
        step(1, 2'd0, 0, 16'h7777, 0, 0, 0);
        chk_stat("R5 taken over", 2'b10, 1'b0);
        chk_regs("R5 trailer regs");
    endtask

    task automatic t_taken();
        step(1, 2'd1, 0, 16'd5, 16'hFFFF, 1, 1);
        chk_stat("R7 error ignored", 2'b10, 1'b0);
        step(1, 2'd3, 1, 16'h0101, 0, 0, 1);
        chk_regs("R7 execution continues");
    endtask

    task automatic t_fail();
        step(0, 2'd0, 0, 0, 0, 1, 1);
        chk_stat("R8 first repair", 2'b01, 1'b1);
        step(0, 2'd0, 0, 0, 0, 1, 1);
        chk_stat("R8 failed", 2'b11, 1'b1);
        rd_sel_i = 0; #0.1;
        chk("R8 read zero", 32'(rd_data_o), 32'h0);
        step(1, 2'd0, 0, 16'h1234, 0, 0, 0);
        chk_stat("R8 failed sticky", 2'b11, 1'b1);
        rd_sel_i = 0; #0.1;
        chk("R8 read still zero", 32'(rd_data_o), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_normal();
        t_idle();
        t_repair();
        t_window_expire();
        t_recur();
        t_taken();
        do_reset();
        t_reset();
        t_fail();
        do_reset();
        t_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule